// File: doc/BRIEF.md
# Pulse-Width Bit Decoder

This block recovers data from a serial line in which each bit cell of length T opens with a rising edge. The high time then encodes the bit. A long pulse of two thirds of the cell stands for 0, and a short pulse of one third of the cell stands for 1. The line is already synchronous to the block clock. Neither input synchronization nor clock recovery happens here.

A one-cycle start strobe marks each rising edge of the line. A single wrapping up/down counter is cleared by the strobe, counts up for every high clock, and counts down for every low clock. The counter's top bit does two jobs. It is the decision, because a cell with more low time than high time leaves the count wrapped negative. It is also a freeze, because counting down stops while that bit is set. At the next start strobe, the top bit is copied into the output register. The output therefore always shows the bit of the cell before the current one.

For correct decoding, a high pulse must last no more than 2^(CNT_W-1) clocks: 512 clocks with the default 10-bit counter. A longer pulse drives the count into the upper half. The count then freezes there, and every such cell reads as 1.

Top module: `pwdec_top`

## Requirements
- R1: While `rst` is high at a clock edge, the counter is loaded with 0 and `bit_out` with 0; `bit_out` reads 0 in the cycle after any reset edge.
- R2: The start strobe is high for exactly one cycle: the first cycle in which `ser_in` is 1 after a cycle in which it was 0. It is never high in the first cycle after reset.
- R3: A clock edge on which the start strobe is high clears the counter to 0, whatever the level of `ser_in`.
- R4: Without the strobe, each clock with `ser_in` = 1 adds one to the counter, modulo 2^CNT_W (1023 goes to 0).
- R5: Without the strobe, each clock with `ser_in` = 0 and counter bit CNT_W-1 clear subtracts one, modulo 2^CNT_W (0 goes to 1023).
- R6: Without the strobe, a clock with `ser_in` = 0 and counter bit CNT_W-1 set leaves the counter unchanged.
- R7: `bit_out` changes only on a clock edge where the start strobe is high. On that edge it takes counter bit CNT_W-1 as it stood before the clear. In the cycle where the line first reads high, the old value is still shown; from the next cycle on, the new one is.
- R8: For a cell of H high clocks followed by L low clocks, with 1 ≤ H ≤ 512, the bit shown during the following cell is 0 when L ≤ H-1 and 1 when L ≥ H. For a 0 cell (H = 2T/3) and a 1 cell (H = T/3), this gives 0 and 1 respectively.
- R9: A high pulse of more than 512 clocks (count reaches 512) is reported as 1, so a stream of over-long 0 cells keeps `bit_out` at 1. The first correctly sized cell afterwards is decoded normally again.
- R10: After reset, at least one idle low clock before the first rising edge makes the first reported bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the line is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial line, already synchronous to `clk` |
| bit_out | output | 1 | Registered bit decoded from the previous cell |

## Verification
The situation that is hardest to reach from the ports is the freeze of the counter in its upper half. The only effect it has at the ports is a 1 where a 0 was sent, and that 1 appears one cell later. The stimulus gets there in two ways. The first is cells whose high time straddles the 512-clock limit (512 versus 513). The second is a run at a cell length just past 768 clocks, followed by a return to short cells, which shows that the next start strobe releases the freeze. Random bit streams at cell lengths from 3 to 768 clocks cover the ordinary decision. Cells where L equals H-1 or H cover the tie point of the comparison.

// File: rtl/pwdec_pkg.sv
package pwdec_pkg;

  typedef enum logic [1:0] {
    CNT_CLEAR = 2'd0,
    CNT_UP    = 2'd1,
    CNT_DOWN  = 2'd2,
    CNT_HOLD  = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/pwdec_edge.sv
module pwdec_edge (
  input  logic clk,
  input  logic rst,
  input  logic ser_in,
  output logic start
);

  logic low_seen_q;

  always_ff @(posedge clk) begin
    if (rst) low_seen_q <= 1'b0;
    else     low_seen_q <= ~ser_in;
  end

  assign start = ser_in & low_seen_q;

  p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

  p_start_after_low_r2: assert property (@(posedge clk) disable iff (rst)
    start |-> (ser_in && !$past(ser_in) && !$past(rst)));

endmodule

// File: rtl/pwdec_counter.sv
module pwdec_counter
  import pwdec_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_in,
  input  logic start,
  output logic cnt_msb
);

  localparam int MSB = CNT_W - 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  cnt_op_e          op;

  always_comb begin
    if (start)              op = CNT_CLEAR;
    else if (ser_in)        op = CNT_UP;
    else if (!cnt_q[MSB])   op = CNT_DOWN;
    else                    op = CNT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case (op)
        CNT_CLEAR: cnt_q <= '0;
        CNT_UP:    cnt_q <= cnt_q + ONE;
        CNT_DOWN:  cnt_q <= cnt_q - ONE;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_msb = cnt_q[MSB];

  p_reset_cnt_r1: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));

  p_clear_on_start_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == '0));

  p_count_up_r4: assert property (@(posedge clk) disable iff (rst)
    (!start && ser_in) |=> (cnt_q == $past(cnt_q) + ONE));

  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    (!start && !ser_in && !cnt_q[MSB]) |=> (cnt_q == $past(cnt_q) - ONE));

  p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (!start && !ser_in && cnt_q[MSB]) |=> $stable(cnt_q));

endmodule

// File: rtl/pwdec_capture.sv
module pwdec_capture (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cnt_msb,
  output logic bit_out
);

  always_ff @(posedge clk) begin
    if (rst)        bit_out <= 1'b0;
    else if (start) bit_out <= cnt_msb;
  end

  p_reset_out_r1: assert property (@(posedge clk)
    rst |=> !bit_out);

  p_out_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(bit_out));

  p_out_load_r7: assert property (@(posedge clk) disable iff (rst)
    start |=> (bit_out == $past(cnt_msb)));

endmodule

// File: rtl/pwdec_top.sv
module pwdec_top #(
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_in,
  output logic bit_out
);

  logic start;
  logic cnt_msb;

  pwdec_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .ser_in (ser_in),
    .start  (start)
  );

  pwdec_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .ser_in  (ser_in),
    .start   (start),
    .cnt_msb (cnt_msb)
  );

  pwdec_capture u_capture (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cnt_msb (cnt_msb),
    .bit_out (bit_out)
  );

endmodule

// File: tb/pwdec_top_bench.sv
`timescale 1ns/1ps
module pwdec_top_bench;

  localparam int CNT_W = 10;
  localparam int HALF  = 2 ** (CNT_W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic bit_out;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  logic shown;
  logic pending;

  always #4 clk = ~clk;

  pwdec_top #(.CNT_W(CNT_W)) u_pwdec_top (
    .clk     (clk),
    .rst     (rst),
    .ser_in  (ser_in),
    .bit_out (bit_out)
  );

  function automatic logic exp_bit(int h, int l);
    return ((h - 1) >= HALF) || (l >= h);
  endfunction

  task automatic chk(logic act, logic exp, string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: bit_out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(logic v);
    @(posedge clk);
    #1 ser_in = v;
    @(negedge clk);
  endtask

  task automatic send_cell(int h, int l, string req);
    for (int j = 0; j < h + l; j++) begin
      tick(j < h);
      if (j == 0) chk(bit_out, shown, "R7 old value in rise cycle");
      if (j == 1) begin
        shown = pending;
        chk(bit_out, shown, req);
      end
    end
    pending = exp_bit(h, l);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ser_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bit_out, 1'b0, "R1 reset value");
    @(posedge clk);
    #1 rst = 1'b0;
    shown = 1'b0;
    repeat (4) tick(1'b0);
    chk(bit_out, 1'b0, "R1 idle after reset");
    pending = 1'b1;
  endtask

  task automatic sweep(int t, int cells, string req);
    for (int k = 0; k < cells; k++) begin
      logic b;
      int   h;
      b = 1'($urandom % 2);
      h = b ? (t / 3) : (2 * t / 3);
      send_cell(h, t - h, req);
    end
  endtask

  initial begin
    do_reset();
    send_cell(4, 2, "R10 first bit after idle");
    send_cell(2, 4, "R8 short 0");
    send_cell(1, 2, "R8 short 1");
    sweep(3, 40, "R8 T=3");
    sweep(6, 40, "R8 T=6");
    sweep(9, 40, "R8 T=9");
    sweep(30, 30, "R8 T=30");
    sweep(300, 20, "R8 T=300");
    // tie point of the comparison
    send_cell(200, 199, "R8 L=H-1");
    send_cell(200, 200, "R8 L=H");
    send_cell(20, 20, "R8 L=H");
    // high-time limit
    send_cell(512, 100, "R9 H=512");
    send_cell(513, 100, "R9 H=513");
    send_cell(30, 10, "R9 recovery");
    sweep(768, 8, "R8 T=768");
    // past the limit: over-long zeros stick high
    for (int k = 0; k < 5; k++) send_cell(514, 257, "R9 stuck high");
    send_cell(257, 514, "R9 stuck high");
    sweep(30, 10, "R9 recovery after stuck");
    // reset in mid stream, then full-range wrap via long low idle
    do_reset();
    send_cell(20, 10, "R10 first bit after mid reset");
    send_cell(2, 1, "R8 after reset");
    send_cell(10, 1030, "R5 wrap and R6 freeze on long low");
    send_cell(3, 1, "R3 clear after freeze");
    send_cell(1, 1, "R4 minimal cell");
    send_cell(2, 1, "R8 end");
    tick(1'b1);
    chk(bit_out, shown, "R7 old value in rise cycle");
    tick(1'b0);
    chk(bit_out, pending, "R2 final strobe");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule